// File: doc/BRIEF.md
# Warp Shared-Memory Bank Conflict Serializer

This block sits in front of a banked scratchpad and serves one read access from a 32-thread warp. Each thread presents a word address, and an active mask says which threads take part. The scratchpad has one read port per bank, so two threads that need different words from the same bank cannot be served together. The block replays the access over as many cycles as the worst bank needs. Threads that ask for the same word share one bank read and receive the same data.

Each cycle, every bank serves the address of its lowest-numbered pending thread. Every pending thread that names that exact address is answered in the same cycle. A per-thread hit vector marks whose data is on the output bus this cycle. A done mask collects the served threads, and a one-cycle completion pulse marks the final service cycle. The bank arrays have no write path. At reset they load a known pattern that depends on the address.

Top module: `smem_bank_serializer`

## Requirements
- R1: After reset, `ready_o` is 1, while `thr_done_o`, `thr_hit_o`, `bank_gnt_o` and `complete_o` are all 0.
- R2: The low 5 address bits select the bank and bits 8:5 select the row. Every word reads as `32'hC0DE0000 + address`. A hit thread's bank has its grant bit set, and that bank's row output equals the thread's row.
- R3: `start_i` is accepted only while `ready_o` is 1, and the request is latched on that clock edge. A `start_i` raised during an access changes neither its duration nor its done mask.
- R4: When all active threads use different banks, the access takes one service cycle.
- R5: When all active threads read one word, the access takes one service cycle with exactly one bank granted.
- R6: The number of service cycles equals the largest count of distinct addresses in any one bank. For example, 8 distinct rows in one bank take 8 cycles.
- R7: In each cycle, each bank serves the address of its lowest-indexed pending thread, together with all pending threads that share that address. Every service cycle before the last serves at least one thread.
- R8: Inactive threads are never hit and never marked done. An all-zero mask completes after one service cycle with no grants.
- R9: `complete_o` is 1 only in the last service cycle. On the next cycle `ready_o` is 1 and `thr_done_o` equals the active mask.
- R10: In a cycle where a thread is hit, its `thr_data_o` slice holds the word at its address.
- R11: No thread is hit more than once per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an access; accepted only when ready |
| mask_i | input | 32 | Active-thread mask |
| addr_i | input | 32*9 | Per-thread word address, thread t at bits [9t+8:9t] |
| ready_o | output | 1 | Idle; a new access may start |
| bank_gnt_o | output | 32 | Banks read this cycle |
| bank_row_o | output | 32*4 | Row read by each bank |
| thr_hit_o | output | 32 | Threads served this cycle |
| thr_data_o | output | 32*32 | Per-thread read data, valid when hit |
| thr_done_o | output | 32 | Threads served so far in this access |
| complete_o | output | 1 | Last service cycle of the access |

## Verification
The checker watches the following properties on every cycle:
- hit threads never overlap the done set;
- no inactive thread is ever hit;
- each hit has a matching bank grant and row;
- each non-final busy cycle makes progress;
- the latched request stays stable while busy;
- completion coincides with a full done mask and is followed by idle.

Some behaviours depend on the whole address pattern, and only the bench scenarios show them:
- the exact service-cycle count for a pattern, including conflict, broadcast and stride cases;
- which address a bank picks first;
- the returned data values;
- that a start request arriving during an access is ignored.

// File: rtl/smem_ser_pkg.sv
package smem_ser_pkg;
  // Preload pattern of the read-only bank arrays
  function automatic logic [31:0] init_word(input int unsigned a);
    return 32'hC0DE_0000 + a;
  endfunction
endpackage

// File: rtl/smem_bank_pick.sv
module smem_bank_pick #(
  parameter int N_THREADS = 32,
  parameter int BANK_W    = 5,
  parameter int ROW_W     = 4,
  parameter int BANK_ID   = 0,
  localparam int ADDR_W   = BANK_W + ROW_W
) (
  input  logic [N_THREADS-1:0]        pend_i,
  input  logic [N_THREADS*ADDR_W-1:0] addr_i,
  output logic                        gnt_o,
  output logic [ROW_W-1:0]            row_o,
  output logic [N_THREADS-1:0]        serve_o
);
  logic             found;
  logic [ROW_W-1:0] row_sel;

  // lowest-indexed pending thread mapped to this bank wins
  always_comb begin
    found   = 1'b0;
    row_sel = '0;
    for (int t = 0; t < N_THREADS; t++) begin
      if (!found && pend_i[t] &&
          addr_i[t*ADDR_W +: BANK_W] == BANK_W'(BANK_ID)) begin
        found   = 1'b1;
        row_sel = addr_i[t*ADDR_W+BANK_W +: ROW_W];
      end
    end
  end

  // broadcast: every pending thread with the same word rides along
  always_comb begin
    for (int t = 0; t < N_THREADS; t++) begin
      serve_o[t] = found && pend_i[t] &&
                   addr_i[t*ADDR_W +: BANK_W] == BANK_W'(BANK_ID) &&
                   addr_i[t*ADDR_W+BANK_W +: ROW_W] == row_sel;
    end
  end

  assign gnt_o = found;
  assign row_o = row_sel;
endmodule

// File: rtl/smem_bank_store.sv
module smem_bank_store #(
  parameter int N_BANKS   = 32,
  parameter int ROW_DEPTH = 16,
  parameter int DATA_W    = 32,
  localparam int ROW_W    = $clog2(ROW_DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_BANKS*ROW_W-1:0]    rd_row_i,
  output logic [N_BANKS*DATA_W-1:0]   rd_data_o
);
  import smem_ser_pkg::*;

  logic [DATA_W-1:0] mem_q [N_BANKS][ROW_DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < N_BANKS; b++)
        for (int r = 0; r < ROW_DEPTH; r++)
          mem_q[b][r] <= DATA_W'(init_word(r * N_BANKS + b));
    end
  end

  for (genvar b = 0; b < N_BANKS; b++) begin : g_rd
    assign rd_data_o[b*DATA_W +: DATA_W] = mem_q[b][rd_row_i[b*ROW_W +: ROW_W]];
  end
endmodule

// File: rtl/smem_bank_serializer.sv
module smem_bank_serializer #(
  parameter int N_THREADS = 32,
  parameter int N_BANKS   = 32,
  parameter int ROW_DEPTH = 16,
  parameter int DATA_W    = 32,
  localparam int BANK_W   = $clog2(N_BANKS),
  localparam int ROW_W    = $clog2(ROW_DEPTH),
  localparam int ADDR_W   = BANK_W + ROW_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [N_THREADS-1:0]          mask_i,
  input  logic [N_THREADS*ADDR_W-1:0]   addr_i,
  output logic                          ready_o,
  output logic [N_BANKS-1:0]            bank_gnt_o,
  output logic [N_BANKS*ROW_W-1:0]      bank_row_o,
  output logic [N_THREADS-1:0]          thr_hit_o,
  output logic [N_THREADS*DATA_W-1:0]   thr_data_o,
  output logic [N_THREADS-1:0]          thr_done_o,
  output logic                          complete_o
);
  logic                        busy_q;
  logic [N_THREADS-1:0]        pend_q, done_q, mask_q, hit;
  logic [N_THREADS*ADDR_W-1:0] addr_q;
  logic [N_THREADS-1:0]        serve_b [N_BANKS];
  logic [N_BANKS*DATA_W-1:0]   bank_rd;
  logic                        last;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    smem_bank_pick #(
      .N_THREADS(N_THREADS), .BANK_W(BANK_W), .ROW_W(ROW_W), .BANK_ID(b)
    ) u_pick (
      .pend_i (pend_q),
      .addr_i (addr_q),
      .gnt_o  (bank_gnt_o[b]),
      .row_o  (bank_row_o[b*ROW_W +: ROW_W]),
      .serve_o(serve_b[b])
    );
  end

  smem_bank_store #(
    .N_BANKS(N_BANKS), .ROW_DEPTH(ROW_DEPTH), .DATA_W(DATA_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_row_i (bank_row_o),
    .rd_data_o(bank_rd)
  );

  always_comb begin
    hit = '0;
    for (int b = 0; b < N_BANKS; b++) hit = hit | serve_b[b];
  end

  // route each bank's word to all threads it served
  for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
    logic [BANK_W-1:0] bsel;
    assign bsel = addr_q[t*ADDR_W +: BANK_W];
    assign thr_data_o[t*DATA_W +: DATA_W] =
      hit[t] ? bank_rd[int'(bsel)*DATA_W +: DATA_W] : '0;
  end

  assign last = busy_q && ((pend_q & ~hit) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= '0;
      done_q <= '0;
      mask_q <= '0;
      addr_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        pend_q <= mask_i;
        done_q <= '0;
        mask_q <= mask_i;
        addr_q <= addr_i;
      end
    end else begin
      pend_q <= pend_q & ~hit;
      done_q <= done_q | hit;
      if (last) busy_q <= 1'b0;
    end
  end

  assign ready_o    = !busy_q;
  assign thr_hit_o  = hit;
  assign thr_done_o = done_q;
  assign complete_o = last;
endmodule

// File: rtl/smem_bank_serializer_chk.sv
module smem_bank_serializer_chk #(
  parameter int N_THREADS = 32,
  parameter int N_BANKS   = 32,
  parameter int ROW_DEPTH = 16,
  localparam int BANK_W   = $clog2(N_BANKS),
  localparam int ROW_W    = $clog2(ROW_DEPTH),
  localparam int ADDR_W   = BANK_W + ROW_W
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        ready_o,
  input logic [N_BANKS-1:0]          bank_gnt_o,
  input logic [N_BANKS*ROW_W-1:0]    bank_row_o,
  input logic [N_THREADS-1:0]        thr_hit_o,
  input logic [N_THREADS-1:0]        thr_done_o,
  input logic                        complete_o,
  input logic [N_THREADS-1:0]        mask_q,
  input logic [N_THREADS*ADDR_W-1:0] addr_q
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (bank_gnt_o == '0 && thr_hit_o == '0 && !complete_o));
  // R11
  no_rehit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_hit_o & thr_done_o) == '0);
  // R8
  inactive_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_hit_o & ~mask_q) == '0);
  // R9
  complete_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete_o |=> ready_o);
  // R9
  complete_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete_o |-> ((thr_done_o | thr_hit_o) == mask_q));
  // R7
  progress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !complete_o) |-> thr_hit_o != '0);
  // R3
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && $past(!ready_o)) |-> ($stable(mask_q) && $stable(addr_q)));

  for (genvar t = 0; t < N_THREADS; t++) begin : g_t
    logic [BANK_W-1:0] bk;
    logic [ROW_W-1:0]  rw;
    assign bk = addr_q[t*ADDR_W +: BANK_W];
    assign rw = addr_q[t*ADDR_W+BANK_W +: ROW_W];
    // R2
    hit_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      thr_hit_o[t] |-> (bank_gnt_o[bk] && bank_row_o[int'(bk)*ROW_W +: ROW_W] == rw));
  end
endmodule

bind smem_bank_serializer smem_bank_serializer_chk #(
  .N_THREADS(N_THREADS), .N_BANKS(N_BANKS), .ROW_DEPTH(ROW_DEPTH)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready_o   (ready_o),
  .bank_gnt_o(bank_gnt_o),
  .bank_row_o(bank_row_o),
  .thr_hit_o (thr_hit_o),
  .thr_done_o(thr_done_o),
  .complete_o(complete_o),
  .mask_q    (mask_q),
  .addr_q    (addr_q)
);

// File: tb/smem_bank_serializer_test.sv
`timescale 1ns/1ps
module smem_bank_serializer_test;
  localparam int NT = 32, NB = 32, AW = 9, DW = 32, RW = 4;

  typedef struct packed {
    logic [31:0] mask;
    logic [3:0]  pat;
    logic [7:0]  cyc;
  } vec_t;

  // pat: 0 addr=t, 1 addr=37, 2 (t%8)*32, 3 (t%16)*32, 4 bank t/2 row t&1, 5 addr=2t
  localparam vec_t VECS [11] = '{
    '{32'hFFFF_FFFF, 4'd0, 8'd1},
    '{32'hFFFF_FFFF, 4'd1, 8'd1},
    '{32'hFFFF_FFFF, 4'd2, 8'd8},
    '{32'h0000_00FF, 4'd2, 8'd8},
    '{32'h0101_0101, 4'd2, 8'd1},
    '{32'hFFFF_FFFF, 4'd3, 8'd16},
    '{32'hFFFF_FFFF, 4'd4, 8'd2},
    '{32'hFFFF_FFFF, 4'd5, 8'd2},
    '{32'h0000_0000, 4'd0, 8'd1},
    '{32'hAAAA_AAAA, 4'd3, 8'd8},
    '{32'h0000_FFFF, 4'd5, 8'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NT-1:0] mask = '0;
  logic [NT*AW-1:0] addr = '0;
  logic ready, complete;
  logic [NB-1:0] gnt;
  logic [NB*RW-1:0] brow;
  logic [NT-1:0] hit, done;
  logic [NT*DW-1:0] data;
  int checks = 0, failures = 0, cycles = 0;

  always #10 clk = ~clk;

  smem_bank_serializer uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mask_i(mask), .addr_i(addr),
    .ready_o(ready), .bank_gnt_o(gnt), .bank_row_o(brow), .thr_hit_o(hit),
    .thr_data_o(data), .thr_done_o(done), .complete_o(complete)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: act=%0d exp<=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [AW-1:0] pat_addr(input logic [3:0] p, input int t);
    case (p)
      4'd0:    return AW'(t);
      4'd1:    return AW'(37);
      4'd2:    return AW'((t % 8) * 32);
      4'd3:    return AW'((t % 16) * 32);
      4'd4:    return AW'(((t & 1) << 5) | (t >> 1));
      default: return AW'(2 * t);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] m, input logic [3:0] p, input int exp_cyc,
                        input string req, input bit interfere);
    int n = 0, cmpl_at = -1, cmpl_cnt = 0, data_err = 0, gmax = 0;
    logic [NT-1:0] served = '0, bad = '0;
    @(negedge clk);
    mask = m;
    for (int t = 0; t < NT; t++) addr[t*AW +: AW] = pat_addr(p, t);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!ready && n < 200) begin
      n++;
      if (complete) begin cmpl_at = n; cmpl_cnt++; end
      if ($countones(gnt) > gmax) gmax = $countones(gnt);
      bad |= (hit & served) | (hit & ~m);
      served |= hit;
      for (int t = 0; t < NT; t++)
        if (hit[t] && data[t*DW +: DW] != 32'hC0DE_0000 + 32'(pat_addr(p, t))) data_err++;
      start = 1'b0;
      if (interfere && n == 3) begin
        start = 1'b1;
        mask = 32'h0000_000F;
        for (int t = 0; t < NT; t++) addr[t*AW +: AW] = AW'(t);
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(n == exp_cyc, req, n, exp_cyc);
    check(cmpl_cnt == 1 && cmpl_at == n, "R9 complete last cycle", cmpl_at, n);
    check(done == m, "R9 done mask", done, m);
    check(data_err == 0, "R10 data", data_err, 0);
    check(bad == '0, "R11/R8 single active service", bad, 0);
    if (p == 4'd1) check(gmax == 1, "R5 one bank granted", gmax, 1);
    if (m == '0) check(gmax == 0, "R8 empty mask no grants", gmax, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(ready == 1'b1, "R1 ready", ready, 1);
    check(done == '0 && hit == '0 && gnt == '0 && !complete, "R1 quiet outputs",
          {done, hit}, 0);

    for (int i = 0; i < 11; i++)
      run_op(VECS[i].mask, VECS[i].pat, int'(VECS[i].cyc),
             (i == 0 || i == 10) ? "R4 distinct banks cycles" :
             (i == 1 || i == 4)  ? "R5 broadcast cycles" : "R6 conflict cycles", 1'b0);

    // R3: start raised mid-access is ignored
    run_op(32'hFFFF_FFFF, 4'd3, 16, "R3 busy start ignored", 1'b1);

    // R7: lowest index picks the row; sharers join the same cycle
    @(negedge clk);
    mask = 32'h0000_000F;
    addr = '0;
    addr[0*AW +: AW] = AW'(64);
    addr[1*AW +: AW] = AW'(0);
    addr[2*AW +: AW] = AW'(64);
    addr[3*AW +: AW] = AW'(3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(hit == 32'hD, "R7 first cycle hits", hit, 32'hD);
    check(gnt == 32'h9, "R7 first cycle grants", gnt, 32'h9);
    check(brow[0 +: RW] == 4'd2, "R2 bank0 row first", brow[0 +: RW], 2);
    check(!complete, "R9 not complete early", complete, 0);
    @(negedge clk);
    check(hit == 32'h2 && complete, "R7 second cycle hit", {complete, hit}, {1'b1, 32'h2});
    check(brow[0 +: RW] == 4'd0, "R2 bank0 row second", brow[0 +: RW], 0);
    check(data[1*DW +: DW] == 32'hC0DE_0000, "R10 row0 word", data[1*DW +: DW], 32'hC0DE_0000);
    @(negedge clk);
    check(ready && done == 32'hF, "R9 idle with done", {ready, done}, {1'b1, 32'hF});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule